// File: doc/BRIEF.md
# Integer Execute Unit

This block is the integer execute stage of a 32-bit load/store RISC pipeline. Each clock it accepts an operation code, two register operands, a 16-bit immediate and a 5-bit immediate shift count. It returns one registered result word. The supported operations are:

- add, subtract and multiply
- bitwise logic, including immediate forms and forms that place the immediate in the upper half of the word
- ten compare relations
- logical shifts, arithmetic shifts and rotates

The unit has no condition flags. A compare writes the value 0 or 1 into the result word. Software that needs carry or overflow derives it with further compares.

Immediate extension happens inside the unit, and the extension rule depends on the operation. Arithmetic operations and signed or equality compares sign-extend the immediate. Logic operations and unsigned compares zero-extend it. The high-immediate logic forms use the immediate as the upper sixteen bits, with zeros below. The result register is the only state in the block.

Top module: `int_exec_unit`

## Requirements
- R1: While `rst_n` is low, `result` is 0. Otherwise `result` takes the value computed from the inputs at a rising edge, after that edge, and holds it until the next edge.
- R2: Operation codes follow the order of `ieu_op_e` in `ieu_pkg`, starting at 0. The operations are: ADD gives a+b; SUB gives a−b; ADDI gives a+sext(imm); SUBI gives a−sext(imm). All wrap modulo 2^32, with no flag output, and give the same bits for signed and unsigned operands.
- R3: MUL gives the low 32 bits of a×b. MULI gives the low 32 bits of a×sext(imm).
- R4: AND, OR, XOR and NOR combine a and b bitwise. NOR is the inverse of OR.
- R5: ANDI, ORI, XORI and NORI combine a with the immediate zero-extended to 32 bits.
- R6: ANDHI, ORHI and XORHI combine a with {imm, 16'h0000}.
- R7: Register compares produce 1 when the relation holds and 0 otherwise. The relations are EQ, NE, LT, LE, GE and GT (signed), and LTU, LEU, GEU and GTU (unsigned).
- R8: Immediate compares sign-extend the immediate for EQ, NE and the signed relations. They zero-extend it for the unsigned relations.
- R9: SLL and SRL shift with zero fill. Register forms take the count from b[4:0] and ignore b[31:5]. Immediate forms SLLI and SRLI take the count from `shamt`.
- R10: SRA and SRAI shift right and refill with a[31].
- R11: ROL (count from b[4:0]) and ROLI (count from `shamt`) rotate left. ROR rotates right with a register count only.
- R12: A shift or rotate by a count of 0 returns a unchanged.
- R13: Operation codes above 45, which are not in `ieu_op_e`, produce 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the result register |
| op_code | input | 6 | Operation code, encoded per `ieu_op_e` |
| src_a | input | 32 | First register operand |
| src_b | input | 32 | Second register operand; low 5 bits are the register shift count |
| imm16 | input | 16 | Immediate field |
| shamt | input | 5 | Immediate shift or rotate count |
| result | output | 32 | Registered result |

## Verification
The only state is the result register, so a fault inside the unit appears in `result` on the edge after the faulty operation is presented. It then disappears when the next operation overwrites it. A wrong extension mode shows only when the immediate's top bit is set, which is why the stimulus favours immediates such as 0x8000 and 0xFFFF. A wrong shift count source shows only when b[4:0] differs from `shamt`, which is why directed cases pair nonzero upper bits of b with distinct counts. Compare faults show at the sign boundary, so operands such as 0x80000000 against 0x7FFFFFFF are mixed in, as are equal operands.

// File: rtl/ieu_pkg.sv
package ieu_pkg;

  typedef enum logic [5:0] {
    OP_ADD, OP_ADDI, OP_SUB, OP_SUBI, OP_MUL, OP_MULI,
    OP_AND, OP_OR, OP_XOR, OP_NOR,
    OP_ANDI, OP_ORI, OP_XORI, OP_NORI,
    OP_ANDHI, OP_ORHI, OP_XORHI,
    OP_CEQ, OP_CNE, OP_CLT, OP_CLE, OP_CGE, OP_CGT,
    OP_CLTU, OP_CLEU, OP_CGEU, OP_CGTU,
    OP_CEQI, OP_CNEI, OP_CLTI, OP_CLEI, OP_CGEI, OP_CGTI,
    OP_CLTUI, OP_CLEUI, OP_CGEUI, OP_CGTUI,
    OP_SLL, OP_SRL, OP_SRA, OP_ROL, OP_ROR,
    OP_SLLI, OP_SRLI, OP_SRAI, OP_ROLI
  } ieu_op_e;

  typedef enum logic [2:0] {
    CLS_NONE, CLS_ARITH, CLS_LOGIC, CLS_CMP, CLS_SHIFT
  } ieu_cls_e;

  typedef enum logic [1:0] {
    SRC_REG, SRC_SEXT, SRC_ZEXT, SRC_HIGH
  } ieu_src_e;

  typedef enum logic [3:0] {
    CK_EQ, CK_NE, CK_LT, CK_LE, CK_GE, CK_GT,
    CK_LTU, CK_LEU, CK_GEU, CK_GTU
  } ieu_cmp_e;

  function automatic ieu_cls_e op_class(ieu_op_e op);
    if (op <= OP_MULI)       return CLS_ARITH;
    else if (op <= OP_XORHI) return CLS_LOGIC;
    else if (op <= OP_CGTUI) return CLS_CMP;
    else if (op <= OP_ROLI)  return CLS_SHIFT;
    else                     return CLS_NONE;
  endfunction

  function automatic ieu_src_e op_source(ieu_op_e op);
    case (op)
      OP_ADDI, OP_SUBI, OP_MULI,
      OP_CEQI, OP_CNEI, OP_CLTI, OP_CLEI, OP_CGEI, OP_CGTI: return SRC_SEXT;
      OP_ANDI, OP_ORI, OP_XORI, OP_NORI,
      OP_CLTUI, OP_CLEUI, OP_CGEUI, OP_CGTUI:               return SRC_ZEXT;
      OP_ANDHI, OP_ORHI, OP_XORHI:                          return SRC_HIGH;
      default:                                              return SRC_REG;
    endcase
  endfunction

  function automatic ieu_cmp_e cmp_kind(ieu_op_e op);
    logic [5:0] d;
    d = (op >= OP_CEQI) ? (6'(op) - 6'(OP_CEQI)) : (6'(op) - 6'(OP_CEQ));
    return ieu_cmp_e'(d[3:0]);
  endfunction

  function automatic logic shift_uses_imm(ieu_op_e op);
    return (op == OP_SLLI) || (op == OP_SRLI) || (op == OP_SRAI) || (op == OP_ROLI);
  endfunction

endpackage

// File: rtl/ieu_operand_sel.sv
module ieu_operand_sel
  import ieu_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16,
  parameter int SH_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ieu_op_e          op,
  input  logic [XLEN-1:0]  reg_b,
  input  logic [IMM_W-1:0] imm,
  input  logic [SH_W-1:0]  shamt_imm,
  output logic [XLEN-1:0]  b_eff,
  output logic [SH_W-1:0]  sh_amt
);
  localparam int PAD = XLEN - IMM_W;

  ieu_src_e src_mode;
  assign src_mode = op_source(op);

  always_comb begin
    case (src_mode)
      SRC_SEXT: b_eff = {{PAD{imm[IMM_W-1]}}, imm};
      SRC_ZEXT: b_eff = {{PAD{1'b0}}, imm};
      SRC_HIGH: b_eff = {imm, {PAD{1'b0}}};
      default:  b_eff = reg_b;
    endcase
  end

  assign sh_amt = shift_uses_imm(op) ? shamt_imm : reg_b[SH_W-1:0];

  // Zero-extended immediates never carry bits into the upper half (R5, R8)
  assert_zext_upper_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (src_mode == SRC_ZEXT) |-> (b_eff[XLEN-1:IMM_W] == '0));

  // High-immediate forms keep the lower half clear (R6)
  assert_high_lower_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (src_mode == SRC_HIGH) |-> (b_eff[PAD-1:0] == '0));

  // Sign extension keeps the immediate's sign in the top bit (R2)
  assert_sext_sign_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (src_mode == SRC_SEXT) |-> (b_eff[XLEN-1] == imm[IMM_W-1]));

endmodule

// File: rtl/ieu_arith_cmp.sv
module ieu_arith_cmp
  import ieu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  ieu_op_e         op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] arith_res,
  output logic            cmp_bit
);

  function automatic logic [XLEN-1:0] negate(logic [XLEN-1:0] v);
    return ~v + XLEN'(1);
  endfunction

  function automatic logic [XLEN-1:0] mul_low(logic [XLEN-1:0] x, logic [XLEN-1:0] y);
    return x * y;
  endfunction

  always_comb begin
    case (op)
      OP_ADD, OP_ADDI: arith_res = a + b;
      OP_SUB:          arith_res = a - b;
      OP_SUBI:         arith_res = a + negate(b);
      OP_MUL, OP_MULI: arith_res = mul_low(a, b);
      default:         arith_res = '0;
    endcase
  end

  logic eq_w, ltu_w, gtu_w, lt_s, gt_s, ge_s;
  assign eq_w  = (a == b);
  assign ltu_w = (a < b);
  assign gtu_w = (a > b);
  assign lt_s  = ($signed(a) < $signed(b));
  assign gt_s  = ($signed(a) > $signed(b));
  assign ge_s  = gt_s | eq_w;

  ieu_cmp_e kind;
  assign kind = cmp_kind(op);

  always_comb begin
    case (kind)
      CK_EQ:   cmp_bit = eq_w;
      CK_NE:   cmp_bit = !eq_w;
      CK_LT:   cmp_bit = lt_s;
      CK_LE:   cmp_bit = lt_s | eq_w;
      CK_GE:   cmp_bit = ge_s;
      CK_GT:   cmp_bit = gt_s;
      CK_LTU:  cmp_bit = ltu_w;
      CK_LEU:  cmp_bit = ltu_w | eq_w;
      CK_GEU:  cmp_bit = gtu_w | eq_w;
      CK_GTU:  cmp_bit = gtu_w;
      default: cmp_bit = 1'b0;
    endcase
  end

  // Signed less-than and greater-or-equal come from separate comparators
  // and must always disagree (R7)
  assert_lt_ge_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lt_s != ge_s);

  // Unsigned ordering: exactly one of less, equal, greater (R7)
  assert_unsigned_trichotomy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ltu_w, eq_w, gtu_w}) == 1);

endmodule

// File: rtl/ieu_logic_shift.sv
module ieu_logic_shift
  import ieu_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int SH_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  ieu_op_e         op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic [SH_W-1:0] sh_amt,
  output logic [XLEN-1:0] logic_res,
  output logic [XLEN-1:0] shift_res
);

  function automatic logic [SH_W:0] complement_amt(logic [SH_W-1:0] k);
    return (SH_W+1)'(XLEN) - {1'b0, k};
  endfunction

  function automatic logic [XLEN-1:0] rot_left(logic [XLEN-1:0] v, logic [SH_W-1:0] k);
    return (v << k) | (v >> complement_amt(k));
  endfunction

  function automatic logic [XLEN-1:0] rot_right(logic [XLEN-1:0] v, logic [SH_W-1:0] k);
    return (v >> k) | (v << complement_amt(k));
  endfunction

  function automatic logic [XLEN-1:0] shr_arith(logic [XLEN-1:0] v, logic [SH_W-1:0] k);
    return $unsigned($signed(v) >>> k);
  endfunction

  always_comb begin
    case (op)
      OP_AND, OP_ANDI, OP_ANDHI: logic_res = a & b;
      OP_OR,  OP_ORI,  OP_ORHI:  logic_res = a | b;
      OP_XOR, OP_XORI, OP_XORHI: logic_res = a ^ b;
      OP_NOR, OP_NORI:           logic_res = ~(a | b);
      default:                   logic_res = '0;
    endcase
  end

  always_comb begin
    case (op)
      OP_SLL, OP_SLLI: shift_res = a << sh_amt;
      OP_SRL, OP_SRLI: shift_res = a >> sh_amt;
      OP_SRA, OP_SRAI: shift_res = shr_arith(a, sh_amt);
      OP_ROL, OP_ROLI: shift_res = rot_left(a, sh_amt);
      OP_ROR:          shift_res = rot_right(a, sh_amt);
      default:         shift_res = '0;
    endcase
  end

  logic is_shift, is_sra, is_rot;
  assign is_shift = (op_class(op) == CLS_SHIFT);
  assign is_sra   = (op == OP_SRA) || (op == OP_SRAI);
  assign is_rot   = (op == OP_ROL) || (op == OP_ROLI) || (op == OP_ROR);

  assert_zero_count_passthrough_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (is_shift && sh_amt == '0) |-> (shift_res == a));

  assert_sra_keeps_sign_R10: assert property (@(posedge clk) disable iff (!rst_n)
    is_sra |-> (shift_res[XLEN-1] == a[XLEN-1]));

  assert_rotate_keeps_ones_R11: assert property (@(posedge clk) disable iff (!rst_n)
    is_rot |-> ($countones(shift_res) == $countones(a)));

endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import ieu_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16,
  localparam int SH_W = $clog2(XLEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [5:0]       op_code,
  input  logic [XLEN-1:0]  src_a,
  input  logic [XLEN-1:0]  src_b,
  input  logic [IMM_W-1:0] imm16,
  input  logic [SH_W-1:0]  shamt,
  output logic [XLEN-1:0]  result
);

  ieu_op_e  op_e;
  ieu_cls_e cls;
  assign op_e = ieu_op_e'(op_code);
  assign cls  = op_class(op_e);

  logic [XLEN-1:0] b_eff;
  logic [SH_W-1:0] sh_amt;
  logic [XLEN-1:0] arith_res, logic_res, shift_res;
  logic            cmp_bit;

  ieu_operand_sel #(.XLEN(XLEN), .IMM_W(IMM_W), .SH_W(SH_W)) u_opsel (
    .clk(clk), .rst_n(rst_n), .op(op_e), .reg_b(src_b), .imm(imm16),
    .shamt_imm(shamt), .b_eff(b_eff), .sh_amt(sh_amt)
  );

  ieu_arith_cmp #(.XLEN(XLEN)) u_arith (
    .clk(clk), .rst_n(rst_n), .op(op_e), .a(src_a), .b(b_eff),
    .arith_res(arith_res), .cmp_bit(cmp_bit)
  );

  ieu_logic_shift #(.XLEN(XLEN), .SH_W(SH_W)) u_lsh (
    .clk(clk), .rst_n(rst_n), .op(op_e), .a(src_a), .b(b_eff),
    .sh_amt(sh_amt), .logic_res(logic_res), .shift_res(shift_res)
  );

  logic [XLEN-1:0] next_res;
  always_comb begin
    case (cls)
      CLS_ARITH: next_res = arith_res;
      CLS_LOGIC: next_res = logic_res;
      CLS_CMP:   next_res = {{(XLEN-1){1'b0}}, cmp_bit};
      CLS_SHIFT: next_res = shift_res;
      default:   next_res = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) result <= '0;
    else        result <= next_res;
  end

  logic was_cmp, was_none;
  assign was_cmp  = (cls == CLS_CMP);
  assign was_none = (cls == CLS_NONE);

  assert_cmp_is_boolean_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(was_cmp) |-> (result[XLEN-1:1] == '0));

  assert_undefined_gives_zero_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $past(was_none) |-> (result == '0));

endmodule

// File: tb/int_exec_unit_tb.sv
module int_exec_unit_tb_top;
  import ieu_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  op_code = '0;
  logic [31:0] src_a = '0, src_b = '0;
  logic [15:0] imm16 = '0;
  logic [4:0]  shamt = '0;
  logic [31:0] result;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  int_exec_unit dut_i (
    .clk(clk), .rst_n(rst_n), .op_code(op_code), .src_a(src_a), .src_b(src_b),
    .imm16(imm16), .shamt(shamt), .result(result)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] shl_ref(logic [31:0] v, int k);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = (i >= k) ? v[i-k] : 1'b0;
    return r;
  endfunction

  function automatic logic [31:0] shr_ref(logic [31:0] v, int k, logic fill);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = (i + k <= 31) ? v[i+k] : fill;
    return r;
  endfunction

  function automatic logic [31:0] rol_ref(logic [31:0] v, int k);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[(i + k) % 32] = v[i];
    return r;
  endfunction

  function automatic logic [31:0] ror_ref(logic [31:0] v, int k);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[(i + k) % 32];
    return r;
  endfunction

  function automatic logic slt_ref(logic [31:0] x, logic [31:0] y);
    return (x ^ 32'h8000_0000) < (y ^ 32'h8000_0000);
  endfunction

  function automatic logic [31:0] cmp_ref(int rel, logic [31:0] x, logic [31:0] y);
    case (rel)
      0: return {31'd0, x == y};
      1: return {31'd0, x != y};
      2: return {31'd0, slt_ref(x, y)};
      3: return {31'd0, !slt_ref(y, x)};
      4: return {31'd0, !slt_ref(x, y)};
      5: return {31'd0, slt_ref(y, x)};
      6: return {31'd0, x < y};
      7: return {31'd0, !(y < x)};
      8: return {31'd0, !(x < y)};
      default: return {31'd0, y < x};
    endcase
  endfunction

  function automatic logic [31:0] expect_of(int op, logic [31:0] a, logic [31:0] b,
                                            logic [15:0] imm, logic [4:0] sh);
    logic [31:0] sx, zx, hi;
    longint unsigned prod;
    int rk, ik;
    sx = {{16{imm[15]}}, imm};
    zx = {16'h0000, imm};
    hi = {imm, 16'h0000};
    rk = int'(b[4:0]);
    ik = int'(sh);
    case (op)
      0:  return a + b;
      1:  return a + sx;
      2:  return a + ~b + 32'd1;
      3:  return a + ~sx + 32'd1;
      4:  begin prod = longint'(a) * longint'(b);  return prod[31:0]; end
      5:  begin prod = longint'(a) * longint'(sx); return prod[31:0]; end
      6:  return a & b;
      7:  return a | b;
      8:  return a ^ b;
      9:  return ~(a | b);
      10: return a & zx;
      11: return a | zx;
      12: return a ^ zx;
      13: return ~(a | zx);
      14: return a & hi;
      15: return a | hi;
      16: return a ^ hi;
      37: return shl_ref(a, rk);
      38: return shr_ref(a, rk, 1'b0);
      39: return shr_ref(a, rk, a[31]);
      40: return rol_ref(a, rk);
      41: return ror_ref(a, rk);
      42: return shl_ref(a, ik);
      43: return shr_ref(a, ik, 1'b0);
      44: return shr_ref(a, ik, a[31]);
      45: return rol_ref(a, ik);
      default: begin
        if (op >= 17 && op <= 26) return cmp_ref(op - 17, a, b);
        if (op >= 27 && op <= 32) return cmp_ref(op - 27, a, sx);
        if (op >= 33 && op <= 36) return cmp_ref(op - 27, a, zx);
        return 32'h0;
      end
    endcase
  endfunction

  function automatic string req_of(int op);
    if (op <= 3)  return "R2";
    if (op <= 5)  return "R3";
    if (op <= 9)  return "R4";
    if (op <= 13) return "R5";
    if (op <= 16) return "R6";
    if (op <= 26) return "R7";
    if (op <= 36) return "R8";
    if (op == 39 || op == 44) return "R10";
    if (op == 40 || op == 41 || op == 45) return "R11";
    if (op <= 45) return "R9";
    return "R13";
  endfunction

  task automatic run_op(int op, logic [31:0] a, logic [31:0] b, logic [15:0] imm,
                        logic [4:0] sh, string req);
    @(negedge clk);
    op_code = 6'(op); src_a = a; src_b = b; imm16 = imm; shamt = sh;
    @(posedge clk);
    #1;
    check(req, result, expect_of(op, a, b, imm, sh), $sformatf("op %0d", op));
  endtask

  function automatic logic [31:0] pick_word();
    int s;
    s = int'($urandom_range(0, 9));
    case (s)
      0: return 32'h0000_0000;
      1: return 32'hFFFF_FFFF;
      2: return 32'h8000_0000;
      3: return 32'h7FFF_FFFF;
      4: return 32'h0000_0001;
      default: return $urandom;
    endcase
  endfunction

  function automatic logic [15:0] pick_imm();
    int s;
    s = int'($urandom_range(0, 7));
    case (s)
      0: return 16'h8000;
      1: return 16'hFFFF;
      2: return 16'h7FFF;
      3: return 16'h0000;
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    op_code = 6'(OP_ADD); src_a = 32'h1234_5678; src_b = 32'h1111_1111;
    repeat (3) @(posedge clk);
    #1;
    check("R1", result, 32'h0, "result in reset");
    @(negedge clk);
    rst_n = 1'b1;

    // R1: value present after the edge, held until the next edge
    @(negedge clk);
    op_code = 6'(OP_ADD); src_a = 32'd5; src_b = 32'd7;
    @(posedge clk); #1;
    check("R1", result, 32'd12, "loaded at edge");
    @(negedge clk);
    src_b = 32'd100;
    #1;
    check("R1", result, 32'd12, "held between edges");

    // R2: wrap, signed/unsigned neutral, subi at sign boundary
    run_op(OP_ADD,  32'hFFFF_FFFF, 32'h0000_0001, 16'h0, 5'd0, "R2");
    run_op(OP_ADD,  32'h7FFF_FFFF, 32'h0000_0001, 16'h0, 5'd0, "R2");
    run_op(OP_SUBI, 32'h0000_0000, 32'h0, 16'h8000, 5'd0, "R2");
    run_op(OP_SUBI, 32'h0000_0010, 32'h0, 16'h0001, 5'd0, "R2");
    run_op(OP_ADDI, 32'h0000_0000, 32'h0, 16'hFFFF, 5'd0, "R2");
    // R3: truncated product, negative immediate
    run_op(OP_MUL,  32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h0, 5'd0, "R3");
    run_op(OP_MULI, 32'h0000_0003, 32'h0, 16'hFFFE, 5'd0, "R3");
    // R4, R5, R6
    run_op(OP_NOR,  32'hF0F0_0000, 32'h0000_0F0F, 16'h0, 5'd0, "R4");
    run_op(OP_ORI,  32'h0000_0000, 32'h0, 16'h8001, 5'd0, "R5");
    run_op(OP_NORI, 32'h0000_0000, 32'h0, 16'hFFFF, 5'd0, "R5");
    run_op(OP_ANDHI, 32'hFFFF_FFFF, 32'h0, 16'hA5A5, 5'd0, "R6");
    run_op(OP_XORHI, 32'h0000_FFFF, 32'h0, 16'hFFFF, 5'd0, "R6");
    // R7: sign boundary and equal operands
    run_op(OP_CLT,  32'h8000_0000, 32'h7FFF_FFFF, 16'h0, 5'd0, "R7");
    run_op(OP_CLTU, 32'h8000_0000, 32'h7FFF_FFFF, 16'h0, 5'd0, "R7");
    run_op(OP_CLE,  32'h1234_0000, 32'h1234_0000, 16'h0, 5'd0, "R7");
    run_op(OP_CGT,  32'h1234_0000, 32'h1234_0000, 16'h0, 5'd0, "R7");
    // R8: immediate with top bit set
    run_op(OP_CLTI,  32'h0000_0000, 32'h0, 16'h8000, 5'd0, "R8");
    run_op(OP_CLTUI, 32'h0000_0000, 32'h0, 16'h8000, 5'd0, "R8");
    run_op(OP_CEQI,  32'hFFFF_FFFF, 32'h0, 16'hFFFF, 5'd0, "R8");
    // R9: upper bits of b ignored, immediate count used for immediate forms
    run_op(OP_SLL,  32'h0000_0001, 32'hFFFF_FFE4, 16'h0, 5'd9, "R9");
    run_op(OP_SRLI, 32'h8000_0000, 32'h0000_0003, 16'h0, 5'd31, "R9");
    // R10
    run_op(OP_SRA,  32'h8000_0000, 32'h0000_001F, 16'h0, 5'd0, "R10");
    run_op(OP_SRAI, 32'h9000_0000, 32'h0, 16'h0, 5'd4, "R10");
    // R11
    run_op(OP_ROL,  32'h8000_0001, 32'h0000_0001, 16'h0, 5'd0, "R11");
    run_op(OP_ROLI, 32'h8000_0001, 32'h0000_0000, 16'h0, 5'd31, "R11");
    run_op(OP_ROR,  32'h0000_0001, 32'h0000_0001, 16'h0, 5'd7, "R11");
    // R12: zero count on each shift kind
    run_op(OP_SRA,  32'h8765_4321, 32'hFFFF_FFE0, 16'h0, 5'd3, "R12");
    run_op(OP_ROR,  32'h8765_4321, 32'h0000_0020, 16'h0, 5'd3, "R12");
    run_op(OP_SLLI, 32'h8765_4321, 32'h0000_0005, 16'h0, 5'd0, "R12");
    // R13
    run_op(46, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, 5'd1, "R13");
    run_op(63, 32'h1234_5678, 32'h1, 16'h1, 5'd1, "R13");

    for (int n = 0; n < 3000; n++) begin
      int op;
      op = int'($urandom_range(0, 63));
      run_op(op, pick_word(), pick_word(), pick_imm(), 5'($urandom), req_of(op));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule